// File: doc/BRIEF.md
# Early Bus Request Generator

This block lives inside the outbound master of a bridge that carries processor cycles onto a PCI bus. It raises the bus request line early, before any transaction is ready. The trigger is a deadlock-breaking retry that the processor-side slave issues while it holds a compelled (non-posted) cycle. When the processor comes back to retry that cycle, the bus is then more likely to be granted already.

A request raised this way is benign. It may be dropped without any transaction starting. It ends on whichever comes first of these:
- a fixed hold window runs out;
- the arbiter grants the bus while no real cycle is ready;
- the master presents a real request, which turns it into an ordinary request.

A single control bit turns the feature off. That bit is set at reset.

Top module: `spec_req_gen`

## Requirements
- R1: While `rst_n` is low and right after its release, `bus_req` is 0 and the enable bit is 1, so speculative requesting works with no prior write.
- R2: In idle, with no real request, a cycle with `lock_retry`=1 and `compelled_held`=1 and the enable bit at 1 makes `bus_req` 1 from the next clock edge. `bus_req` comes straight from a flop.
- R3: A `lock_retry` pulse without `compelled_held`, or `compelled_held` without `lock_retry`, leaves `bus_req` at 0.
- R4: With no grant and no real request, a speculative request stays high for exactly HOLD_CYC (default 16) clock cycles and then drops.
- R5: `real_req`=1 makes `bus_req` 1 one edge later, also during a speculative request. It then stays 1 for as long as `real_req` stays 1, with no timeout. It falls one edge after `real_req` falls.
- R6: `bus_gnt`=1 during a speculative request with `real_req`=0 releases `bus_req` at the next edge.
- R7: A further `lock_retry` during an active speculative request does not restart the hold window.
- R8: A cycle with `ctl_we`=1 loads `ctl_wdata` into the enable bit. With the bit at 0, lock events raise no request. Writing 1 restores the behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the enable bit |
| ctl_wdata | input | 1 | Value written to the enable bit (1 = enabled) |
| compelled_held | input | 1 | Slave is holding a compelled cycle |
| lock_retry | input | 1 | Deadlock-resolution retry event, one cycle |
| real_req | input | 1 | Master has a real transaction ready |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Registered bus request, active high |

## Verification
Every response of this block is due exactly one clock edge after the input that causes it:
- a lock event while a compelled cycle is held raises the request;
- a grant releases it;
- a real request asserts it;
- a real request falling drops it.

The hold window ends on the 16th edge after entry. The bench drives inputs on the falling edge and samples `bus_req` on the next falling edge, which is the first point after the edge that must change it. For the timeout and the retrigger cases, it counts the falling-edge samples with `bus_req` high over a fixed window and compares that count with 16.

// File: rtl/spec_req_pkg.sv
package spec_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SPEC = 2'd1,
    ST_REAL = 2'd2
  } spec_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/spec_ctl_bit.sv
module spec_ctl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_wdata,
  output logic spec_en
);
  logic en_d;
  logic en_q;

  always_comb begin
    en_d = en_q;
    if (ctl_we) en_d = ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b1;
    else if (ctl_we) en_q <= en_d;
  end

  assign spec_en = en_q;
endmodule

// File: rtl/spec_timer.sv
module spec_timer #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = spec_req_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign cnt_en = clr | run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/spec_fsm.sv
module spec_fsm
  import spec_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic spec_en,
  input  logic compelled_held,
  input  logic lock_retry,
  input  logic real_req,
  input  logic bus_gnt,
  input  logic tmr_done,
  output logic tmr_clr,
  output logic tmr_run,
  output logic req_q
);
  spec_state_e state_d;
  spec_state_e state_q;
  logic        req_d;

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (real_req) begin
          state_d = ST_REAL;
        end else if (lock_retry && compelled_held && spec_en) begin
          state_d = ST_SPEC;
          tmr_clr = 1'b1;
        end
      end
      ST_SPEC: begin
        if (real_req)                  state_d = ST_REAL;
        else if (bus_gnt || tmr_done)  state_d = ST_IDLE;
        else                           tmr_run = 1'b1;
      end
      ST_REAL: begin
        if (!real_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    req_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/spec_req_gen.sv
module spec_req_gen #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_wdata,
  input  logic compelled_held,
  input  logic lock_retry,
  input  logic real_req,
  input  logic bus_gnt,
  output logic bus_req
);
  logic spec_en;
  logic tmr_clr;
  logic tmr_run;
  logic tmr_done;

  spec_ctl_bit u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .spec_en   (spec_en)
  );

  spec_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  spec_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .spec_en        (spec_en),
    .compelled_held (compelled_held),
    .lock_retry     (lock_retry),
    .real_req       (real_req),
    .bus_gnt        (bus_gnt),
    .tmr_done       (tmr_done),
    .tmr_clr        (tmr_clr),
    .tmr_run        (tmr_run),
    .req_q          (bus_req)
  );
endmodule

// File: rtl/spec_req_chk.sv
module spec_req_chk #(
  parameter int unsigned HOLD_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic spec_en,
  input logic compelled_held,
  input logic lock_retry,
  input logic real_req,
  input logic bus_gnt,
  input logic bus_req
);
  localparam int unsigned RW = spec_req_pkg::cnt_width(HOLD_CYC + 2) + 1;

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   run_cnt <= '0;
    else if (!(bus_req && !real_req))             run_cnt <= '0;
    else if (run_cnt != {RW{1'b1}})               run_cnt <= run_cnt + 1'b1;
  end

  // R2
  spec_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !real_req && lock_retry && compelled_held && spec_en) |=> bus_req);

  // R3
  no_stray_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !real_req && !(lock_retry && compelled_held)) |=> !bus_req);

  // R4
  hold_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RW'(HOLD_CYC));

  // R5
  real_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    real_req |=> bus_req);

  // R6
  gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !real_req) |=> !bus_req);
endmodule

bind spec_req_gen spec_req_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .spec_en        (spec_en),
  .compelled_held (compelled_held),
  .lock_retry     (lock_retry),
  .real_req       (real_req),
  .bus_gnt        (bus_gnt),
  .bus_req        (bus_req)
);

// File: tb/spec_req_gen_bench.sv
`timescale 1ns/1ps
module spec_req_gen_bench;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic ctl_wdata = 1'b0;
  logic compelled_held = 1'b0;
  logic lock_retry = 1'b0;
  logic real_req = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spec_req_gen #(.HOLD_CYC(HOLD)) u_spec_req_gen (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .compelled_held(compelled_held), .lock_retry(lock_retry),
    .real_req(real_req), .bus_gnt(bus_gnt), .bus_req(bus_req)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    lock_retry = 0; compelled_held = 0; real_req = 0; bus_gnt = 0; ctl_we = 0;
    repeat (HOLD + 4) tick();
  endtask

  task automatic pulse_lock();
    compelled_held = 1; lock_retry = 1;
    tick();
    lock_retry = 0;
  endtask

  task automatic t_reset();
    tick();
    chk(bus_req, 0, "R1 req during reset");
    rst_n = 1;
    tick();
    chk(bus_req, 0, "R1 req after reset");
    pulse_lock();
    chk(bus_req, 1, "R1 enabled by default");
    settle();
  endtask

  task automatic t_raise_and_timeout();
    int n = 0;
    pulse_lock();
    chk(bus_req, 1, "R2 raise next edge");
    for (int i = 0; i < 40; i++) begin
      if (bus_req) n++;
      tick();
    end
    chk(n, HOLD, "R4 hold length");
    chk(bus_req, 0, "R4 dropped");
    settle();
  endtask

  task automatic t_no_trigger();
    compelled_held = 0; lock_retry = 1;
    tick();
    lock_retry = 0;
    chk(bus_req, 0, "R3 lock without compelled");
    compelled_held = 1;
    repeat (3) tick();
    chk(bus_req, 0, "R3 compelled without lock");
    settle();
  endtask

  task automatic t_real_convert();
    pulse_lock();
    repeat (3) tick();
    real_req = 1;
    tick();
    chk(bus_req, 1, "R5 real during spec");
    repeat (30) tick();
    chk(bus_req, 1, "R5 no timeout on real");
    real_req = 0;
    tick();
    chk(bus_req, 0, "R5 drop after real falls");
    settle();
    real_req = 1;
    tick();
    chk(bus_req, 1, "R5 real from idle");
    settle();
  endtask

  task automatic t_grant_release();
    pulse_lock();
    repeat (2) tick();
    bus_gnt = 1;
    tick();
    bus_gnt = 0;
    chk(bus_req, 0, "R6 released on grant");
    tick();
    chk(bus_req, 0, "R6 stays released");
    settle();
  endtask

  task automatic t_retrigger();
    int n = 0;
    pulse_lock();
    for (int i = 0; i < 40; i++) begin
      if (bus_req) n++;
      lock_retry = (i == 5);
      tick();
    end
    chk(n, HOLD, "R7 window not restarted");
    settle();
  endtask

  task automatic t_ctl_bit();
    ctl_we = 1; ctl_wdata = 0;
    tick();
    ctl_we = 0;
    pulse_lock();
    chk(bus_req, 0, "R8 disabled no req");
    tick();
    chk(bus_req, 0, "R8 disabled stays low");
    ctl_we = 1; ctl_wdata = 1;
    tick();
    ctl_we = 0;
    pulse_lock();
    chk(bus_req, 1, "R8 re-enabled");
    settle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_raise_and_timeout();
    t_no_trigger();
    t_real_convert();
    t_grant_release();
    t_retrigger();
    t_ctl_bit();
    finish_run();
  end

  initial begin
    #(4 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule